// File: doc/BRIEF.md
# Serial Slave Front End with Register Pointer

This block is the two-wire serial slave that sits in front of an eight-bit I/O expander's register bank. It filters the raw clock and data lines, recognises START, repeated START and STOP conditions, and compares the incoming 7-bit address with a fixed upper field joined to three strap pins. In a write transfer, the first byte after the address is a register pointer. Every later byte is handed to the register bank as a one-cycle write strobe with its data. In a read transfer, the block fetches the byte of the register the pointer selects, shifts it out MSB first, and fetches again each time the master acknowledges.

SDA is driven open-drain. The block only asserts a pull-down enable; the line itself is the wired-AND of all drivers. The pointer survives STOP and repeated START, so a write of only the pointer byte, followed by a read, selects what is read. An asynchronous active-low reset, which covers both the external reset and power-on reset, holds the protocol machine idle. It also clears the pointer and releases SDA.

Top module: `i2cx_slave_front`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `sda_oe_o` is 0, `ptr_o` is 0, and neither strobe pulses until a transfer addresses the block.
- R2: The block acknowledges an address byte only when its upper seven bits equal `{ADDR_HI, addr_sel_i}`. `ADDR_HI` defaults to 4'b0011. Bit 0 is the read flag: 1 means read. For any other address it gives no ACK, no strobe and no pointer change until the next START.
- R3: The acknowledge for a matched address, a valid pointer byte or a write byte is `sda_oe_o` = 1 throughout the ninth SCL high phase.
- R4: The first byte after a write address loads `ptr_o` when its value is below 4 (0 = input, 1 = output, 2 = polarity, 3 = direction). A larger value gets no ACK and leaves `ptr_o` unchanged. `ptr_o` only changes while the filtered SCL is low.
- R5: Each later byte of a write transfer produces one `wr_pulse_o`, with that byte on `wr_data_o` and `ptr_o` unchanged. The pointer does not advance between bytes.
- R6: A write byte while the pointer is 0 is acknowledged but produces no `wr_pulse_o`.
- R7: A read transfer shifts out `rd_data_i` of the current pointer, MSB first. The value is sampled on the SCL fall that ends the previous acknowledge, marked by one `rd_pulse_o`. SDA is driven low only for 0 bits.
- R8: A master ACK (SDA low in the ninth read clock) starts another byte of the same register. A NACK releases SDA for the rest of the transfer, with no further `rd_pulse_o`.
- R9: The pointer holds its value across STOP and repeated START. A later read returns the register it selects.
- R10: A change on SCL or SDA reaches the protocol logic only after the synchronised level has held for 3 consecutive clocks (`STABLE_CYC`). A 2-clock pulse has no effect.
- R11: `wr_pulse_o` and `rd_pulse_o` are single-cycle and never high together.
- R12: `sda_oe_o` changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line (wired level) |
| addr_sel_i | input | 3 | Address strap pins, low address bits |
| rd_data_i | input | 8 | Register bank read data for `ptr_o` |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| ptr_o | output | 2 | Register pointer |
| rd_pulse_o | output | 1 | Read fetch strobe |
| wr_pulse_o | output | 1 | Write strobe |
| wr_data_o | output | 8 | Write data, valid with `wr_pulse_o` |

## Verification
The assertions take a well-formed bus for granted: the master moves SDA only while SCL is low, except for START and STOP. It never issues START or STOP while the slave holds SDA low. SCL phases last much longer than the filter and synchroniser delay. The bench master holds every quarter bit for ten clocks, about twice that delay. It ends every read with a NACK before STOP. The only line disturbances it injects are the deliberate 2- and 5-clock SDA pulses in the filter test.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_WAIT
  } slv_state_e;
endpackage

// File: rtl/i2cx_glitch_filter.sv
module i2cx_glitch_filter #(
  parameter int W          = 2,
  parameter int STABLE_CYC = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] flt_o
);
  localparam int CW = $clog2(STABLE_CYC + 1);

  for (genvar g = 0; g < W; g++) begin : g_line
    logic          s1_q, s2_q, out_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q  <= 1'b1;
        s2_q  <= 1'b1;
        out_q <= 1'b1;
        cnt_q <= '0;
      end else begin
        s1_q <= raw_i[g];
        s2_q <= s1_q;
        if (s2_q == out_q) begin
          cnt_q <= '0;
        end else if (cnt_q == CW'(STABLE_CYC - 1)) begin
          out_q <= s2_q;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end

    assign sync_o[g] = s2_q;
    assign flt_o[g]  = out_q;
  end
endmodule

// File: rtl/i2cx_bus_events.sv
module i2cx_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = !scl_q && scl_i;
  assign scl_fall_o = scl_q && !scl_i;
  // data edge while clock held high
  assign start_o    = scl_q && scl_i && sda_q && !sda_i;
  assign stop_o     = scl_q && scl_i && !sda_q && sda_i;
endmodule

// File: rtl/i2cx_slave_fsm.sv
module i2cx_slave_fsm
  import i2cx_pkg::*;
#(
  parameter int          HI_W     = 4,
  parameter logic [HI_W-1:0] ADDR_HI = 4'b0011,
  parameter int          SEL_W    = 3,
  parameter int          NUM_REGS = 4,
  parameter int          DW       = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        scl_rise_i,
  input  logic                        scl_fall_i,
  input  logic                        start_i,
  input  logic                        stop_i,
  input  logic                        sda_i,
  input  logic [SEL_W-1:0]            addr_sel_i,
  input  logic [DW-1:0]               rd_data_i,
  output logic                        sda_oe_o,
  output logic [$clog2(NUM_REGS)-1:0] ptr_o,
  output logic                        rd_pulse_o,
  output logic                        wr_pulse_o,
  output logic [DW-1:0]               wr_data_o
);
  localparam int PTR_W = $clog2(NUM_REGS);
  localparam int CNT_W = $clog2(DW + 1);
  localparam int AW    = HI_W + SEL_W;

  slv_state_e     state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DW-1:0]  sr_q, tx_q;
  logic           rw_q, mack_q;
  logic           rx_state, byte_done, addr_hit, cmd_ok;

  assign rx_state  = state_q inside {ST_ADDR, ST_CMD, ST_WR};
  assign byte_done = scl_fall_i && (cnt_q == CNT_W'(DW));
  assign addr_hit  = sr_q[DW-1 -: AW] == {ADDR_HI, addr_sel_i};
  assign cmd_ok    = int'(sr_q) < NUM_REGS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      sr_q       <= '0;
      tx_q       <= '0;
      rw_q       <= 1'b0;
      mack_q     <= 1'b0;
      sda_oe_o   <= 1'b0;
      ptr_o      <= '0;
      rd_pulse_o <= 1'b0;
      wr_pulse_o <= 1'b0;
      wr_data_o  <= '0;
    end else begin
      rd_pulse_o <= 1'b0;
      wr_pulse_o <= 1'b0;
      if (start_i) begin
        state_q  <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        if (scl_rise_i && rx_state && cnt_q != CNT_W'(DW)) begin
          sr_q  <= {sr_q[DW-2:0], sda_i};
          cnt_q <= cnt_q + 1'b1;
        end
        unique case (state_q)
          ST_ADDR: if (byte_done) begin
            cnt_q <= '0;
            if (addr_hit) begin
              sda_oe_o <= 1'b1;
              rw_q     <= sr_q[0];
              state_q  <= ST_ADDR_ACK;
            end else begin
              state_q <= ST_WAIT;
            end
          end
          ST_ADDR_ACK: if (scl_fall_i) begin
            cnt_q <= '0;
            if (rw_q) begin
              tx_q       <= rd_data_i;
              rd_pulse_o <= 1'b1;
              sda_oe_o   <= !rd_data_i[DW-1];
              state_q    <= ST_RD;
            end else begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_CMD;
            end
          end
          ST_CMD: if (byte_done) begin
            cnt_q <= '0;
            if (cmd_ok) begin
              ptr_o    <= sr_q[PTR_W-1:0];
              sda_oe_o <= 1'b1;
              state_q  <= ST_CMD_ACK;
            end else begin
              state_q <= ST_WAIT;
            end
          end
          ST_CMD_ACK, ST_WR_ACK: if (scl_fall_i) begin
            sda_oe_o <= 1'b0;
            cnt_q    <= '0;
            state_q  <= ST_WR;
          end
          ST_WR: if (byte_done) begin
            cnt_q      <= '0;
            sda_oe_o   <= 1'b1;
            // pointer 0 is the read-only input register
            wr_pulse_o <= ptr_o != '0;
            wr_data_o  <= sr_q;
            state_q    <= ST_WR_ACK;
          end
          ST_RD: if (scl_fall_i) begin
            if (cnt_q == CNT_W'(DW - 1)) begin
              sda_oe_o <= 1'b0;
              cnt_q    <= '0;
              state_q  <= ST_RD_ACK;
            end else begin
              tx_q     <= {tx_q[DW-2:0], 1'b0};
              sda_oe_o <= !tx_q[DW-2];
              cnt_q    <= cnt_q + 1'b1;
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) mack_q <= !sda_i;
            if (scl_fall_i) begin
              if (mack_q) begin
                tx_q       <= rd_data_i;
                rd_pulse_o <= 1'b1;
                sda_oe_o   <= !rd_data_i[DW-1];
                cnt_q      <= '0;
                state_q    <= ST_RD;
              end else begin
                state_q <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cx_slave_front.sv
module i2cx_slave_front #(
  parameter logic [3:0] ADDR_HI    = 4'b0011,
  parameter int         STABLE_CYC = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] addr_sel_i,
  input  logic [7:0] rd_data_i,
  output logic       sda_oe_o,
  output logic [1:0] ptr_o,
  output logic       rd_pulse_o,
  output logic       wr_pulse_o,
  output logic [7:0] wr_data_o
);
  logic scl_flt, sda_flt, scl_sync, sda_sync;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2cx_glitch_filter #(.W(2), .STABLE_CYC(STABLE_CYC)) u_flt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  ({scl_i, sda_i}),
    .sync_o ({scl_sync, sda_sync}),
    .flt_o  ({scl_flt, sda_flt})
  );

  i2cx_bus_events u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_flt),
    .sda_i      (sda_flt),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2cx_slave_fsm #(
    .HI_W(4), .ADDR_HI(ADDR_HI), .SEL_W(3), .NUM_REGS(4), .DW(8)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .sda_i      (sda_flt),
    .addr_sel_i (addr_sel_i),
    .rd_data_i  (rd_data_i),
    .sda_oe_o   (sda_oe_o),
    .ptr_o      (ptr_o),
    .rd_pulse_o (rd_pulse_o),
    .wr_pulse_o (wr_pulse_o),
    .wr_data_o  (wr_data_o)
  );
endmodule

// File: rtl/i2cx_slave_front_chk.sv
module i2cx_slave_front_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_flt,
  input logic       scl_sync,
  input logic       sda_oe_o,
  input logic [1:0] ptr_o,
  input logic       rd_pulse_o,
  input logic       wr_pulse_o
);
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_pulse_o && rd_pulse_o)); // R11
  AST_WR_ONE_CYC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse_o |=> !wr_pulse_o); // R11
  AST_RD_ONE_CYC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pulse_o |=> !rd_pulse_o); // R11
  AST_NO_WR_INPUT_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse_o |-> ptr_o != 2'd0); // R6
  AST_PTR_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ptr_o) |-> !scl_flt); // R4
  AST_SDA_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_flt); // R12
  AST_FILTER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(scl_flt) |-> ($past(scl_sync, 1) == scl_flt && $past(scl_sync, 2) == scl_flt
                           && $past(scl_sync, 3) == scl_flt)); // R10
endmodule

bind i2cx_slave_front i2cx_slave_front_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_flt    (scl_flt),
  .scl_sync   (scl_sync),
  .sda_oe_o   (sda_oe_o),
  .ptr_o      (ptr_o),
  .rd_pulse_o (rd_pulse_o),
  .wr_pulse_o (wr_pulse_o)
);

// File: tb/i2cx_slave_front_tb.sv
module i2cx_slave_front_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1, sda_glitch = 1'b0;
  logic [2:0] sel = 3'b101;
  logic [7:0] in_val = 8'h00;
  logic [7:0] rd_data;
  logic       sda_oe, rd_pulse, wr_pulse;
  logic [1:0] ptr;
  logic [7:0] wr_data;
  logic       sda_line, sda_in;
  logic [7:0] bank [4];
  int         wr_cnt, rd_cnt, n_chk, n_err;
  logic [7:0] last_wr_data;
  logic [1:0] last_wr_ptr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;
  assign sda_in   = sda_line & ~sda_glitch;
  assign rd_data  = (ptr == 2'd0) ? in_val : bank[ptr];

  i2cx_slave_front dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_in),
    .addr_sel_i (sel),
    .rd_data_i  (rd_data),
    .sda_oe_o   (sda_oe),
    .ptr_o      (ptr),
    .rd_pulse_o (rd_pulse),
    .wr_pulse_o (wr_pulse),
    .wr_data_o  (wr_data)
  );

  // register bank model beside the block
  always @(negedge clk) begin
    if (!rst_n) begin
      wr_cnt <= 0;
      rd_cnt <= 0;
      for (int i = 0; i < 4; i++) bank[i] <= 8'h00;
    end else begin
      if (wr_pulse) begin
        wr_cnt       <= wr_cnt + 1;
        last_wr_data <= wr_data;
        last_wr_ptr  <= ptr;
        bank[ptr]    <= wr_data;
      end
      if (rd_pulse) rd_cnt <= rd_cnt + 1;
    end
  end

  function automatic logic [7:0] abyte(input logic [2:0] s, input logic rd);
    return {4'b0011, s, rd};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    sda_m = 1'b0; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    sda_m = 1'b1; tick(2 * Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, input int glen, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(Q);
      if (i == 3 && glen > 0) begin
        sda_glitch = 1'b1; tick(glen); sda_glitch = 1'b0;
      end
      tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = !sda_line;
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_m = 1'b1; tick(Q);
      b[i] = sda_line;
      tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = !mack; tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic       ack;
    logic [7:0] rb;
    int         w0, r0;
    int unsigned seed;
    seed = $urandom(32'h5EED1234);
    n_chk = 0; n_err = 0;

    tick(5);
    chk("R1", "oe in reset", int'(sda_oe), 0);
    chk("R1", "ptr in reset", int'(ptr), 0);
    rst_n = 1'b1;
    tick(20);
    chk("R1", "oe after reset", int'(sda_oe), 0);
    chk("R1", "strobes after reset", wr_cnt + rd_cnt, 0);

    // write pointer 2 then two data bytes
    bus_start();
    wr_byte(abyte(sel, 1'b0), 0, ack); chk("R2", "addr ack", int'(ack), 1);
    wr_byte(8'h02, 0, ack);            chk("R3", "cmd ack", int'(ack), 1);
    chk("R4", "ptr load", int'(ptr), 2);
    wr_byte(8'hA5, 0, ack);            chk("R3", "data ack", int'(ack), 1);
    chk("R5", "wr count", wr_cnt, 1);
    chk("R5", "wr data", int'(last_wr_data), 'hA5);
    wr_byte(8'h3C, 0, ack);
    chk("R5", "second wr count", wr_cnt, 2);
    chk("R5", "no auto increment", int'(last_wr_ptr), 2);
    chk("R5", "bank value", int'(bank[2]), 'h3C);
    bus_stop();

    // write then read with repeated start; ACK, NACK, then extra clocks
    bus_start();
    wr_byte(abyte(sel, 1'b0), 0, ack);
    wr_byte(8'h01, 0, ack);
    wr_byte(8'h5A, 0, ack);
    bus_rstart();
    r0 = rd_cnt;
    wr_byte(abyte(sel, 1'b1), 0, ack); chk("R2", "read addr ack", int'(ack), 1);
    rd_byte(1'b1, rb); chk("R7", "read byte 1", int'(rb), 'h5A);
    rd_byte(1'b0, rb); chk("R8", "read after ack same reg", int'(rb), 'h5A);
    chk("R8", "oe after nack", int'(sda_oe), 0);
    rd_byte(1'b0, rb); chk("R8", "bus idle after nack", int'(rb), 'hFF);
    chk("R8", "fetch count", rd_cnt - r0, 2);
    bus_stop();

    // pointer kept across stop
    bus_start();
    wr_byte(abyte(sel, 1'b1), 0, ack);
    rd_byte(1'b0, rb); chk("R9", "ptr kept across stop", int'(rb), 'h5A);
    bus_stop();

    // foreign addresses
    w0 = wr_cnt;
    bus_start();
    wr_byte(abyte(sel ^ 3'b001, 1'b0), 0, ack); chk("R2", "low bits mismatch", int'(ack), 0);
    wr_byte(8'h03, 0, ack);                     chk("R2", "ignored byte", int'(ack), 0);
    bus_stop();
    bus_start();
    wr_byte({4'b0100, sel, 1'b0}, 0, ack);      chk("R2", "high bits mismatch", int'(ack), 0);
    wr_byte(8'h02, 0, ack);
    bus_stop();
    chk("R2", "ptr untouched", int'(ptr), 1);
    chk("R2", "no write", wr_cnt - w0, 0);

    // out-of-range pointer
    bus_start();
    wr_byte(abyte(sel, 1'b0), 0, ack);
    wr_byte(8'h07, 0, ack); chk("R4", "bad cmd nack", int'(ack), 0);
    chk("R4", "ptr kept on bad cmd", int'(ptr), 1);
    wr_byte(8'h11, 0, ack);
    bus_stop();
    chk("R4", "no write after bad cmd", wr_cnt - w0, 0);

    // write to input register
    in_val = 8'hC3;
    bus_start();
    wr_byte(abyte(sel, 1'b0), 0, ack);
    wr_byte(8'h00, 0, ack); chk("R4", "ptr 0", int'(ptr), 0);
    wr_byte(8'hEE, 0, ack); chk("R6", "input reg ack", int'(ack), 1);
    chk("R6", "no strobe for reg 0", wr_cnt - w0, 0);
    bus_rstart();
    wr_byte(abyte(sel, 1'b1), 0, ack);
    rd_byte(1'b0, rb); chk("R7", "input reg read", int'(rb), 'hC3);
    bus_stop();

    // SDA glitches while SCL high
    bus_start();
    wr_byte(abyte(sel, 1'b0), 0, ack);
    wr_byte(8'h03, 0, ack);
    wr_byte(8'h9F, 2, ack); chk("R10", "short glitch ack", int'(ack), 1);
    chk("R10", "short glitch data", int'(last_wr_data), 'h9F);
    w0 = wr_cnt;
    wr_byte(8'h48, 5, ack); chk("R10", "long glitch aborts", int'(ack), 0);
    chk("R10", "no write after abort", wr_cnt - w0, 0);
    bus_stop();
    bus_start();
    wr_byte(abyte(sel, 1'b1), 0, ack);
    rd_byte(1'b0, rb); chk("R10", "register intact", int'(rb), 'h9F);
    bus_stop();

    // constrained random write/readback
    for (int it = 0; it < 12; it++) begin
      logic [1:0] c;
      logic [7:0] d;
      sel    = 3'($urandom);
      c      = 2'(1 + ($urandom % 3));
      d      = 8'($urandom);
      in_val = 8'($urandom);
      w0 = wr_cnt;
      bus_start();
      wr_byte(abyte(sel, 1'b0), 0, ack); chk("R2", "rand addr ack", int'(ack), 1);
      wr_byte({6'd0, c}, 0, ack);
      wr_byte(d, 0, ack);
      chk("R5", "rand wr data", int'(last_wr_data), int'(d));
      chk("R5", "rand wr ptr", int'(last_wr_ptr), int'(c));
      bus_rstart();
      wr_byte(abyte(sel, 1'b1), 0, ack);
      rd_byte(1'b0, rb); chk("R7", "rand readback", int'(rb), int'(d));
      if (it % 3 == 0) begin
        bus_rstart();
        wr_byte(abyte(sel, 1'b0), 0, ack);
        wr_byte(8'h00, 0, ack);
        bus_rstart();
        wr_byte(abyte(sel, 1'b1), 0, ack);
        rd_byte(1'b0, rb); chk("R7", "rand input read", int'(rb), int'(in_val));
      end
      bus_stop();
    end

    // reset in mid transfer
    bus_start();
    wr_byte(abyte(sel, 1'b0), 0, ack);
    wr_byte(8'h02, 0, ack);
    sda_m = 1'b0; tick(Q);
    rst_n = 1'b0; tick(4);
    chk("R1", "ptr cleared by reset", int'(ptr), 0);
    chk("R1", "oe cleared by reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    scl_m = 1'b1; tick(2 * Q);
    sda_m = 1'b1; tick(2 * Q);
    chk("R1", "idle after reset", int'(sda_oe), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule